// File: doc/BRIEF.md
# Circular Floating-Point Register Stack

This block is the operand store of a stack-organised floating-point unit. It holds eight 80-bit extended-precision words in a physical file. Every access is made relative to a 3-bit top pointer, so operand `k` is the word `k` places below the current top. A push moves the top pointer down by one, modulo the depth, and loads the new top. A pop hands out the current top and moves the pointer back up. The operands are not moved.

Every cycle the surrounding datapath can read two stack-relative operands combinationally. In the same cycle it can issue one stack operation:
- load a value,
- load zero,
- discard the top,
- overwrite a stack-relative slot,
- the fused "write operand 1, then pop" step that ends an arithmetic-and-pop instruction.

Each physical register carries a valid tag. Pushing onto an occupied register raises an overflow flag. Touching an empty register raises an underflow flag. In both cases the offending operation leaves the stack unchanged.

Top module: `fp_reg_stack`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the top pointer to 0 and empties all eight registers. After reset, both read ports report invalid for every relative index, and `ovf_o` and `unf_o` are low.
- R2: Read port A returns the physical register at `(top + rd_a_idx_i) mod 8`, and read port B returns the one at `(top + rd_b_idx_i) mod 8`. Each port also returns that register's valid tag. Both ports are combinational and show the state before this cycle's operation.
- R3: `op_i` = 1 (load) moves the top pointer to `(top - 1) mod 8`, so 0 wraps to 7. It writes `wr_data_i` there and marks the register valid. The old operand `k` becomes operand `k+1`. Each word is packed as sign in bit 79, exponent in bits 78:64 and fraction in bits 63:0.
- R4: `op_i` = 2 (load zero) behaves like load but writes the all-zero 80-bit word, which is +0.0.
- R5: `op_i` = 3 (pop) marks the current top register empty and moves the top pointer to `(top + 1) mod 8`.
- R6: `op_i` = 4 (write) stores `wr_data_i` into operand `wr_idx_i` and does not move the top pointer.
- R7: `op_i` = 5 (write-then-pop) completes in one cycle:
  - it stores `wr_data_i` into operand 1;
  - it empties the old top;
  - it moves the top pointer up by one, so the written value becomes the new operand 0.
- R8: A load or load-zero whose target register is already valid changes nothing. It drives `ovf_o` high for exactly the following cycle.
- R9: `unf_o` goes high for exactly the following cycle, and the operation changes nothing, in each of these cases:
  - a pop with operand 0 empty;
  - a write to an empty operand;
  - a write-then-pop with operand 0 or operand 1 empty.

  An enabled read of an empty operand also raises `unf_o` but does not block that cycle's operation. Codes 0, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Stack operation code (see R3 to R9) |
| wr_idx_i | input | 3 | Relative operand index for the write operation |
| wr_data_i | input | 80 | Value for load, write and write-then-pop |
| rd_a_en_i | input | 1 | Port A read is used; when set, an empty operand raises underflow |
| rd_a_idx_i | input | 3 | Relative operand index for port A |
| rd_a_data_o | output | 80 | Port A word |
| rd_a_valid_o | output | 1 | Port A register tag |
| rd_b_en_i | input | 1 | Port B read is used; when set, an empty operand raises underflow |
| rd_b_idx_i | input | 3 | Relative operand index for port B |
| rd_b_data_o | output | 80 | Port B word |
| rd_b_valid_o | output | 1 | Port B register tag |
| top_o | output | 3 | Current physical top pointer |
| ovf_o | output | 1 | Overflow pulse, one cycle after the rejected load |
| unf_o | output | 1 | Underflow pulse, one cycle after the offending access |

## Verification
- A wrong top pointer shows on `top_o` at the next edge. In the same cycle it also shifts every relative read, so the data on both ports is wrong at once.
- A stale or missing tag stays hidden until something touches that register. It then appears as a wrong valid bit on a read port, or as a missing or spurious overflow or underflow pulse one cycle after the access.
- A misdirected write is caught only when the corrupted operand is read later. For that reason the bench sweeps every relative index after full-stack loads and mixes in a long pseudo-random run of operations.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_PUSH  = 3'd1,
      OP_PUSHZ = 3'd2,
      OP_POP   = 3'd3,
      OP_WRITE = 3'd4,
      OP_WRPOP = 3'd5
   } stk_op_e;
endpackage

// File: rtl/fpstk_map.sv
// Relative-to-physical index translation; the add wraps at the pointer width.
module fpstk_map #(
   parameter int PTR_W = 3
) (
   input  logic [PTR_W-1:0] top_i,
   input  logic [PTR_W-1:0] rel_i,
   output logic [PTR_W-1:0] phys_o
);
   assign phys_o = top_i + rel_i;
endmodule

// File: rtl/fpstk_tags.sv
module fpstk_tags #(
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             set_en,
   input  logic [PTR_W-1:0] set_idx,
   input  logic             clr_en,
   input  logic [PTR_W-1:0] clr_idx,
   output logic [DEPTH-1:0] tag_o
);
   logic [DEPTH-1:0] tag_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_tag
      always_ff @(posedge clk) begin
         if (rst)
            tag_q[g] <= 1'b0;
         else if (set_en && set_idx == PTR_W'(g))
            tag_q[g] <= 1'b1;
         else if (clr_en && clr_idx == PTR_W'(g))
            tag_q[g] <= 1'b0;
      end
   end

   assign tag_o = tag_q;

   // every accepted operation fills or empties at most one register
   AST_ONE_TAG_MOVES: assert property (@(posedge clk) disable iff (rst)
      $countones(tag_q ^ $past(tag_q)) <= 1); // R3

   always_comb begin
      if (set_en && clr_en)
         AST_NO_SET_CLR_SAME: assert (set_idx != clr_idx); // R7
   end
endmodule

// File: rtl/fpstk_file.sv
module fpstk_file #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 80,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [PTR_W-1:0] waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [PTR_W-1:0] raddr_a,
   input  logic [PTR_W-1:0] raddr_b,
   output logic [WIDTH-1:0] rdata_a,
   output logic [WIDTH-1:0] rdata_b
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack
   import fpstk_pkg::*;
#(
   parameter int EXP_W  = 15,
   parameter int FRAC_W = 64,
   parameter int DEPTH  = 8,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int PTR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        op_i,
   input  logic [PTR_W-1:0]  wr_idx_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic              rd_a_en_i,
   input  logic [PTR_W-1:0]  rd_a_idx_i,
   output logic [WORD_W-1:0] rd_a_data_o,
   output logic              rd_a_valid_o,
   input  logic              rd_b_en_i,
   input  logic [PTR_W-1:0]  rd_b_idx_i,
   output logic [WORD_W-1:0] rd_b_data_o,
   output logic              rd_b_valid_o,
   output logic [PTR_W-1:0]  top_o,
   output logic              ovf_o,
   output logic              unf_o
);
   // elaboration-time parameter checks
   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (EXP_W < 2 || FRAC_W < 1) begin : g_bad_fmt
      $error("exponent and fraction widths too small");
   end

   localparam int NMAP = 5;
   localparam int M_RDA = 0, M_RDB = 1, M_WR = 2, M_ONE = 3, M_PUSH = 4;

   stk_op_e                      op;
   logic [PTR_W-1:0]             top_q, top_d;
   logic [DEPTH-1:0]             tags;
   logic [NMAP-1:0][PTR_W-1:0]   rel_v, phys_v;
   logic                         we, set_en, clr_en, ovf_d, unf_d;
   logic [PTR_W-1:0]             waddr, set_idx, clr_idx;
   logic [WORD_W-1:0]            wdata;

   assign op = stk_op_e'(op_i);

   // stack-relative translation for every port that names an operand
   assign rel_v[M_RDA]  = rd_a_idx_i;
   assign rel_v[M_RDB]  = rd_b_idx_i;
   assign rel_v[M_WR]   = wr_idx_i;
   assign rel_v[M_ONE]  = PTR_W'(1);
   assign rel_v[M_PUSH] = '1;          // minus one: the slot a push lands in

   for (genvar g = 0; g < NMAP; g++) begin : g_map
      fpstk_map #(.PTR_W(PTR_W)) u_map (
         .top_i  (top_q),
         .rel_i  (rel_v[g]),
         .phys_o (phys_v[g])
      );
   end

   // operation decode with guard checks
   always_comb begin
      we      = 1'b0;
      waddr   = phys_v[M_PUSH];
      wdata   = wr_data_i;
      set_en  = 1'b0;
      set_idx = phys_v[M_PUSH];
      clr_en  = 1'b0;
      clr_idx = top_q;
      top_d   = top_q;
      ovf_d   = 1'b0;
      unf_d   = (rd_a_en_i && !tags[phys_v[M_RDA]]) ||
                (rd_b_en_i && !tags[phys_v[M_RDB]]);
      case (op)
         OP_PUSH, OP_PUSHZ: begin
            if (tags[phys_v[M_PUSH]]) begin
               ovf_d = 1'b1;
            end else begin
               we     = 1'b1;
               wdata  = (op == OP_PUSHZ) ? '0 : wr_data_i;
               set_en = 1'b1;
               top_d  = phys_v[M_PUSH];
            end
         end
         OP_POP: begin
            if (!tags[top_q]) begin
               unf_d = 1'b1;
            end else begin
               clr_en = 1'b1;
               top_d  = phys_v[M_ONE];
            end
         end
         OP_WRITE: begin
            if (!tags[phys_v[M_WR]]) begin
               unf_d = 1'b1;
            end else begin
               we    = 1'b1;
               waddr = phys_v[M_WR];
            end
         end
         OP_WRPOP: begin
            if (!tags[top_q] || !tags[phys_v[M_ONE]]) begin
               unf_d = 1'b1;
            end else begin
               we     = 1'b1;
               waddr  = phys_v[M_ONE];
               clr_en = 1'b1;
               top_d  = phys_v[M_ONE];
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         top_q <= '0;
         ovf_o <= 1'b0;
         unf_o <= 1'b0;
      end else begin
         top_q <= top_d;
         ovf_o <= ovf_d;
         unf_o <= unf_d;
      end
   end

   fpstk_tags #(.DEPTH(DEPTH)) u_tags (
      .clk     (clk),
      .rst     (rst),
      .set_en  (set_en),
      .set_idx (set_idx),
      .clr_en  (clr_en),
      .clr_idx (clr_idx),
      .tag_o   (tags)
   );

   fpstk_file #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_file (
      .clk     (clk),
      .we      (we),
      .waddr   (waddr),
      .wdata   (wdata),
      .raddr_a (phys_v[M_RDA]),
      .raddr_b (phys_v[M_RDB]),
      .rdata_a (rd_a_data_o),
      .rdata_b (rd_b_data_o)
   );

   assign rd_a_valid_o = tags[phys_v[M_RDA]];
   assign rd_b_valid_o = tags[phys_v[M_RDB]];
   assign top_o        = top_q;

   // assertions next to the pointer and flag logic
   AST_PUSH_MOVES_DOWN: assert property (@(posedge clk) disable iff (rst)
      set_en |=> (top_q == $past(top_q - PTR_W'(1)))); // R3
   AST_POP_EMPTIES_OLD_TOP: assert property (@(posedge clk) disable iff (rst)
      (clr_en && !we) |=> !tags[$past(top_q)]); // R5
   AST_WRPOP_NEW_TOP_FULL: assert property (@(posedge clk) disable iff (rst)
      (clr_en && we) |=> (tags[top_q] && !tags[$past(top_q)])); // R7
   AST_NO_OVERFLOW_MOVE: assert property (@(posedge clk) disable iff (rst)
      ovf_o |-> (top_q == $past(top_q))); // R8
   AST_UNF_BLOCKS_POP: assert property (@(posedge clk) disable iff (rst)
      (op == OP_POP && !tags[top_q]) |=> (unf_o && top_q == $past(top_q))); // R9
endmodule

// File: tb/sim_fp_reg_stack.sv
module sim_fp_reg_stack;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  op_i = 3'd0;
   logic [2:0]  wr_idx_i = 3'd0;
   logic [79:0] wr_data_i = '0;
   logic        rd_a_en_i = 1'b0, rd_b_en_i = 1'b0;
   logic [2:0]  rd_a_idx_i = 3'd0, rd_b_idx_i = 3'd0;
   logic [79:0] rd_a_data_o, rd_b_data_o;
   logic        rd_a_valid_o, rd_b_valid_o;
   logic [2:0]  top_o;
   logic        ovf_o, unf_o;

   always #5 clk = ~clk;   // 100 MHz

   fp_reg_stack u0 (.*);

   typedef struct {
      logic       ovf;
      logic       unf;
      logic [2:0] top;
      string      req;
   } exp_t;

   exp_t        sb[$];
   int          n_vec = 0, n_miss = 0;
   bit          done = 1'b0;

   // reference state, kept from the requirements only
   logic [79:0] m_reg [8];
   logic        m_tag [8];
   logic [2:0]  m_top;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [79:0] act, input logic [79:0] exp);
      n_vec++;
      if (!ok) begin
         n_miss++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: flags and pointer settle after the edge that takes the op
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t it;
         it = sb.pop_front();
         chk(ovf_o == it.ovf, it.req, "ovf_o", 80'(ovf_o), 80'(it.ovf));
         chk(unf_o == it.unf, it.req, "unf_o", 80'(unf_o), 80'(it.unf));
         chk(top_o == it.top, it.req, "top_o", 80'(top_o), 80'(it.top));
      end
   end

   // driver: applies one op, checks the reads against pre-op state,
   // queues the expected flags and pointer
   task automatic step(input logic [2:0] op, input logic [79:0] d,
                       input logic [2:0] widx, input bit ae, input logic [2:0] ai,
                       input bit be, input logic [2:0] bi, input string req);
      exp_t       it;
      logic [2:0] pa, pb, pp, p1, pw;
      @(negedge clk);
      op_i = op; wr_data_i = d; wr_idx_i = widx;
      rd_a_en_i = ae; rd_a_idx_i = ai; rd_b_en_i = be; rd_b_idx_i = bi;
      #1;
      pa = m_top + ai; pb = m_top + bi;
      chk(rd_a_valid_o == m_tag[pa], {req, " R2"}, "rd_a_valid", 80'(rd_a_valid_o), 80'(m_tag[pa]));
      chk(rd_b_valid_o == m_tag[pb], {req, " R2"}, "rd_b_valid", 80'(rd_b_valid_o), 80'(m_tag[pb]));
      if (m_tag[pa]) chk(rd_a_data_o == m_reg[pa], {req, " R2"}, "rd_a_data", rd_a_data_o, m_reg[pa]);
      if (m_tag[pb]) chk(rd_b_data_o == m_reg[pb], {req, " R2"}, "rd_b_data", rd_b_data_o, m_reg[pb]);
      it.req = req;
      it.ovf = 1'b0;
      it.unf = (ae && !m_tag[pa]) || (be && !m_tag[pb]);
      pp = m_top - 3'd1; p1 = m_top + 3'd1; pw = m_top + widx;
      case (op)
         3'd1, 3'd2: if (m_tag[pp]) it.ovf = 1'b1;
                     else begin m_reg[pp] = (op == 3'd2) ? '0 : d; m_tag[pp] = 1'b1; m_top = pp; end
         3'd3: if (!m_tag[m_top]) it.unf = 1'b1;
               else begin m_tag[m_top] = 1'b0; m_top = p1; end
         3'd4: if (!m_tag[pw]) it.unf = 1'b1;
               else m_reg[pw] = d;
         3'd5: if (!m_tag[m_top] || !m_tag[p1]) it.unf = 1'b1;
               else begin m_reg[p1] = d; m_tag[m_top] = 1'b0; m_top = p1; end
         default: ;
      endcase
      it.top = m_top;
      sb.push_back(it);
   endtask

   function automatic logic [79:0] mk(input int k);
      return {k[0], 15'(k * 37 + 16383), 64'(k) * 64'h9E37_79B9_7F4A_7C15};
   endfunction

   // sweep every relative index on both ports, no operation
   task automatic sweep(input string req);
      for (int i = 0; i < 8; i++)
         step(3'd0, '0, 3'd0, 1'b0, 3'(i), 1'b0, 3'(7 - i), req);
   endtask

   initial begin
      logic [15:0] lf;
      for (int i = 0; i < 8; i++) begin m_reg[i] = '0; m_tag[i] = 1'b0; end
      m_top = 3'd0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      #1;
      chk(top_o == 3'd0, "R1", "top after reset", 80'(top_o), 80'd0);
      chk(!ovf_o && !unf_o, "R1", "flags after reset", 80'({ovf_o, unf_o}), 80'd0);
      sweep("R1 empty after reset");

      step(3'd1, mk(1), 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, "R3 first load wraps top to 7");
      step(3'd2, mk(9), 3'd0, 1'b1, 3'd0, 1'b1, 3'd1, "R4 load zero");
      step(3'd0, '0, 3'd0, 1'b1, 3'd0, 1'b1, 3'd1, "R4 zero on top, old value below");
      for (int k = 2; k < 8; k++)
         step(3'd1, mk(k), 3'd0, 1'b1, 3'd0, 1'b0, 3'd0, "R3 fill");
      sweep("R3 full stack");
      step(3'd1, mk(99), 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, "R8 ninth load");
      step(3'd2, '0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, "R8 load zero when full");
      sweep("R8 state unchanged");
      step(3'd4, mk(50), 3'd3, 1'b1, 3'd3, 1'b0, 3'd0, "R6 write operand 3");
      step(3'd0, '0, 3'd0, 1'b1, 3'd3, 1'b1, 3'd0, "R6 readback");
      step(3'd5, mk(60), 3'd0, 1'b1, 3'd0, 1'b1, 3'd1, "R7 write-then-pop");
      step(3'd0, '0, 3'd0, 1'b1, 3'd0, 1'b1, 3'd7, "R7 result is new top, old top empty");
      for (int k = 0; k < 7; k++)
         step(3'd3, '0, 3'd0, 1'b1, 3'd0, 1'b0, 3'd0, "R5 pop");
      step(3'd3, '0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, "R9 pop of empty");
      step(3'd4, mk(3), 3'd2, 1'b0, 3'd0, 1'b0, 3'd0, "R9 write to empty");
      step(3'd0, '0, 3'd0, 1'b1, 3'd5, 1'b0, 3'd0, "R9 enabled read of empty");
      step(3'd1, mk(4), 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, "R3 single load");
      step(3'd5, mk(5), 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, "R9 write-then-pop with one operand");
      step(3'd1, mk(6), 3'd0, 1'b1, 3'd4, 1'b0, 3'd0, "R9 read underflow does not block load");
      step(3'd6, mk(7), 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, "R9 unused code does nothing");
      sweep("R9 state after unused code");

      lf = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(3'(lf[2:0] % 3'd6), mk(n + 100), lf[5:3], lf[6], lf[9:7],
              lf[10], lf[13:11], "R2 random mix");
      end
      sweep("R2 final sweep");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_miss++;
         $display("FAIL watchdog R1-chain actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   end
endmodule